// File: doc/BRIEF.md
# Condition Code and Interrupt Mask Register

This block holds the processor's 8-bit condition code state: five status flags (half carry, negative, zero, overflow, carry), a maskable interrupt mask, a non-maskable interrupt mask and a stop-disable bit. The bits are placed, from bit 7 down to bit 0, as stop-disable S, non-maskable mask X, half carry H, maskable mask I, N, Z, V, C. The execution unit feeds in flag results with an operation class and a per-flag enable mask. Software can write the whole register. A return-from-interrupt restore port reloads it from the stacked byte.

The block also decides whether a pending interrupt is taken. A non-maskable request is taken only while X is clear. A maskable request is latched and held until I is clear, and the non-maskable request wins when both are eligible. The sequencer does the stacking and then pulses an entry strobe. That strobe sets the masks before the vector fetch: both X and I for the non-maskable case, and I alone for the maskable case. A stop request produces either an execute decision or a no-operation decision, depending on S.

Top module: `ccr_unit`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, `ccr_q` reads 8'hD0 (S, X and I set, all status flags clear) and no maskable request is pending.
- R2: With `alu_upd` high and `alu_kind`=0 (masked class), each of N, Z, V, C (`alu_we` bits 3..0, `alu_flags` bits 3..0) is loaded from its flag input only where its enable bit is 1. H and the mask bits are unchanged.
- R3: With `alu_upd` high and `alu_kind`=1 (add class), H, N, Z, V and C are all loaded from `alu_flags` bits 4..0.
- R4: With `alu_upd` high and `alu_kind`=2 (index step), only Z is loaded, from `alu_flags` bit 2. `alu_kind`=3 changes no flag.
- R5: A software write (`sw_we`) loads every bit from `sw_data`. The exception is X: a 0 in bit 6 clears X, but a 1 in bit 6 cannot set an X that is already clear.
- R6: An RTI restore (`rti_we`) loads the register from `rti_data` under the same X rule. When `rti_we` and `sw_we` are both high in the same cycle, the restore wins. Either full load overrides any flag update in the same cycle.
- R7: `take_xirq` is high exactly when `xirq_req` is high and X is 0.
- R8: The `ent_xirq` strobe sets both X and I on the next edge, overriding any load in the same cycle.
- R9: The `ent_irq` strobe sets I on the next edge and leaves X unchanged.
- R10: A one-cycle `irq_req` pulse is remembered while I is 1. `take_irq` rises once I is 0, and the memory is cleared by `ent_irq`.
- R11: When the non-maskable and maskable requests are eligible together, only `take_xirq` is high.
- R12: With `stop_req` high, `stop_go` is high when S is 0 and `stop_nop` is high when S is 1. Both are low without `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_upd | input | 1 | Flag update strobe from the execution unit |
| alu_kind | input | 2 | Operation class: 0 masked, 1 add, 2 index step, 3 none |
| alu_we | input | 4 | Per-flag enables for N, Z, V, C (masked class) |
| alu_flags | input | 5 | Flag results H, N, Z, V, C (bits 4..0) |
| sw_we | input | 1 | Software register write |
| sw_data | input | 8 | Software write value |
| rti_we | input | 1 | RTI restore strobe |
| rti_data | input | 8 | Stacked value being restored |
| ent_xirq | input | 1 | Non-maskable entry strobe, pulsed after stacking |
| ent_irq | input | 1 | Maskable entry strobe, pulsed after stacking |
| xirq_req | input | 1 | Non-maskable request level |
| irq_req | input | 1 | Maskable request event |
| stop_req | input | 1 | A stop instruction is being decoded |
| ccr_q | output | 8 | Register value |
| take_xirq | output | 1 | Non-maskable request is accepted |
| take_irq | output | 1 | Maskable request is accepted |
| stop_go | output | 1 | Stop is executed |
| stop_nop | output | 1 | Stop is treated as a no-operation |

## Verification
The in-design properties assume that the sequencer pulses at most one entry strobe per cycle, and that each strobe follows a matching take decision. They also assume that a flag update, when it matters to a property, is not masked by a full load in the same cycle, so every property that checks a flag update carries that condition in its antecedent. The stimulus raises one entry strobe at a time, and only after the matching take output has been observed high. It drives `irq_req` as single-cycle pulses. Only in the one step that tests override priority does it overlap full loads with flag updates.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
// Package: bit layout, operation classes and reset value of the condition
// code register. Assumes an 8-bit register whose layout other logic decodes.
package ccr_pkg;
    localparam int CCR_W   = 8;
    localparam int STAT_W  = 5;           // H,N,Z,V,C
    localparam int NZVC_W  = 4;
    localparam int KIND_W  = 2;
    localparam int MASK_W  = 3;           // S,X,I

    // Register bit positions (fixed layout, decoded by stacking logic)
    localparam int B_S = 7;
    localparam int B_X = 6;
    localparam int B_H = 5;
    localparam int B_I = 4;
    localparam int B_N = 3;
    localparam int B_Z = 2;
    localparam int B_V = 1;
    localparam int B_C = 0;

    // Positions inside the status vector {H,N,Z,V,C}
    localparam int SV_H = 4;
    localparam int SV_Z = 2;

    // Positions inside the mask vector {S,X,I}
    localparam int MV_S = 2;
    localparam int MV_X = 1;
    localparam int MV_I = 0;

    localparam logic [CCR_W-1:0] CCR_RST = 8'hD0;

    typedef enum logic [KIND_W-1:0] {
        K_MASKED = 2'd0,
        K_ADD    = 2'd1,
        K_IDX    = 2'd2,
        K_NONE   = 2'd3
    } alu_kind_e;
endpackage

// File: rtl/ccr_status.sv
`timescale 1ns/1ps
// Status flag store for H,N,Z,V,C. A full load (software or restore, already
// selected by the parent) overrides any ALU update in the same cycle.
// Assumes alu_kind is a valid ccr_pkg::alu_kind_e encoding.
module ccr_status
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_upd,
    input  logic [KIND_W-1:0] alu_kind,
    input  logic [NZVC_W-1:0] alu_we,
    input  logic [STAT_W-1:0] alu_flags,
    input  logic              ld_en,
    input  logic [STAT_W-1:0] ld_val,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] upd_bit;
    logic [STAT_W-1:0] stat_n;

    // Per-flag update select for N,Z,V,C: one cell per flag
    for (genvar g = 0; g < NZVC_W; g++) begin : g_nzvc
        assign upd_bit[g] = alu_upd &&
            ((alu_kind == K_MASKED && alu_we[g]) ||
             (alu_kind == K_ADD) ||
             (alu_kind == K_IDX && g == SV_Z));
    end
    // H follows only the add class
    assign upd_bit[SV_H] = alu_upd && (alu_kind == K_ADD);

    // Next-state selection: full load first, then per-flag ALU update
    always_comb begin
        for (int b = 0; b < STAT_W; b++) begin
            stat_n[b] = ld_en ? ld_val[b] : (upd_bit[b] ? alu_flags[b] : stat_q[b]);
        end
    end

    // Flag register with synchronous reset to all-clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_n;
    end

    AST_MASKED_KEEPS_H: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && alu_kind == K_MASKED && !ld_en) |=> $stable(stat_q[SV_H])); // R2
    AST_ADD_LOADS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && alu_kind == K_ADD && !ld_en) |=> (stat_q == $past(alu_flags))); // R3
    AST_IDX_ONLY_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && alu_kind == K_IDX && !ld_en) |=>
            ($stable(stat_q[4:3]) && $stable(stat_q[1:0]))); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (stat_q == $past(ld_val))); // R6
endmodule

// File: rtl/ccr_masks.sv
`timescale 1ns/1ps
// Mask and control bits S, X, I. X may be cleared by a load but is set only
// by reset or non-maskable entry. Assumes entry strobes are single-cycle.
module ccr_masks
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [MASK_W-1:0] ld_val,
    input  logic              ent_xirq,
    input  logic              ent_irq,
    output logic [MASK_W-1:0] mask_q
);
    logic [MASK_W-1:0] mask_n;

    // Next-state: load with X clear-only guard, then entry strobes force masks
    always_comb begin
        mask_n = mask_q;
        if (ld_en) begin
            mask_n[MV_S] = ld_val[MV_S];
            mask_n[MV_X] = mask_q[MV_X] & ld_val[MV_X];
            mask_n[MV_I] = ld_val[MV_I];
        end
        if (ent_xirq) begin
            mask_n[MV_X] = 1'b1;
            mask_n[MV_I] = 1'b1;
        end
        if (ent_irq) mask_n[MV_I] = 1'b1;
    end

    // Mask register; reset sets S, X and I
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_n;
    end

    AST_X_NOT_SET_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[MV_X] && !ent_xirq) |=> !mask_q[MV_X]); // R5
    AST_XIRQ_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        ent_xirq |=> (mask_q[MV_X] && mask_q[MV_I])); // R8
    AST_IRQ_ENTRY_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_irq && !ent_xirq && !ld_en) |=> (mask_q[MV_I] && $stable(mask_q[MV_X]))); // R9
endmodule

// File: rtl/ccr_arb.sv
`timescale 1ns/1ps
// Interrupt acceptance and stop decision. Remembers a maskable request event
// until its entry strobe; the non-maskable request is a level, not latched.
module ccr_arb
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_bit,
    input  logic x_bit,
    input  logic i_bit,
    input  logic xirq_req,
    input  logic irq_req,
    input  logic ent_irq,
    input  logic stop_req,
    output logic take_xirq,
    output logic take_irq,
    output logic stop_go,
    output logic stop_nop
);
    logic pend_q;
    logic irq_live;

    // Acceptance decisions; non-maskable request wins a tie
    always_comb begin
        irq_live  = pend_q | irq_req;
        take_xirq = xirq_req & ~x_bit;
        take_irq  = irq_live & ~i_bit & ~take_xirq;
        stop_go   = stop_req & ~s_bit;
        stop_nop  = stop_req & s_bit;
    end

    // Pending memory: cleared by entry, set by a new request event
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~ent_irq) | irq_req;
    end

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_xirq, take_irq})); // R11
    AST_XIRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        x_bit |-> !take_xirq); // R7
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && i_bit && !ent_irq) |=> pend_q); // R10
    AST_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_go && stop_nop)); // R12
endmodule

// File: rtl/ccr_unit.sv
`timescale 1ns/1ps
// Top: condition code register with interrupt mask handling. Selects the
// full-load source (restore over software), splits it into the status and
// mask stores, and assembles the register in its fixed bit layout.
// Assumes stacking/vector fetch are sequenced outside and signalled by strobes.
module ccr_unit
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_upd,
    input  logic [KIND_W-1:0] alu_kind,
    input  logic [NZVC_W-1:0] alu_we,
    input  logic [STAT_W-1:0] alu_flags,
    input  logic              sw_we,
    input  logic [CCR_W-1:0]  sw_data,
    input  logic              rti_we,
    input  logic [CCR_W-1:0]  rti_data,
    input  logic              ent_xirq,
    input  logic              ent_irq,
    input  logic              xirq_req,
    input  logic              irq_req,
    input  logic              stop_req,
    output logic [CCR_W-1:0]  ccr_q,
    output logic              take_xirq,
    output logic              take_irq,
    output logic              stop_go,
    output logic              stop_nop
);
    logic              ld_en;
    logic [CCR_W-1:0]  ld_word;
    logic [STAT_W-1:0] stat_q;
    logic [MASK_W-1:0] mask_q;

    // Full-load source select: restore has priority over software write
    always_comb begin
        ld_en   = rti_we | sw_we;
        ld_word = rti_we ? rti_data : sw_data;
    end

    ccr_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_upd   (alu_upd),
        .alu_kind  (alu_kind),
        .alu_we    (alu_we),
        .alu_flags (alu_flags),
        .ld_en     (ld_en),
        .ld_val    ({ld_word[B_H], ld_word[B_N], ld_word[B_Z], ld_word[B_V], ld_word[B_C]}),
        .stat_q    (stat_q)
    );

    ccr_masks u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_val   ({ld_word[B_S], ld_word[B_X], ld_word[B_I]}),
        .ent_xirq (ent_xirq),
        .ent_irq  (ent_irq),
        .mask_q   (mask_q)
    );

    ccr_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_bit     (mask_q[MV_S]),
        .x_bit     (mask_q[MV_X]),
        .i_bit     (mask_q[MV_I]),
        .xirq_req  (xirq_req),
        .irq_req   (irq_req),
        .ent_irq   (ent_irq),
        .stop_req  (stop_req),
        .take_xirq (take_xirq),
        .take_irq  (take_irq),
        .stop_go   (stop_go),
        .stop_nop  (stop_nop)
    );

    // Register assembly in the fixed S,X,H,I,N,Z,V,C layout
    always_comb begin
        ccr_q = {mask_q[MV_S], mask_q[MV_X], stat_q[SV_H], mask_q[MV_I], stat_q[3:0]};
    end

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> (ccr_q == CCR_RST)); // R1
endmodule

// File: tb/ccr_unit_tb.sv
`timescale 1ns/1ps
module ccr_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alu_upd = 1'b0;
    logic [1:0] alu_kind = 2'd3;
    logic [3:0] alu_we = '0;
    logic [4:0] alu_flags = '0;
    logic sw_we = 1'b0, rti_we = 1'b0;
    logic [7:0] sw_data = '0, rti_data = '0;
    logic ent_xirq = 1'b0, ent_irq = 1'b0, xirq_req = 1'b0, irq_req = 1'b0, stop_req = 1'b0;
    logic [7:0] ccr_q;
    logic take_xirq, take_irq, stop_go, stop_nop;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit m_valid = 0;
    // reference model state: one integer per bit, plus pending memory
    int mS, mX, mH, mI, mN, mZ, mV, mC, mPend;

    always #2.5 clk = ~clk;

    ccr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_kind(alu_kind),
        .alu_we(alu_we), .alu_flags(alu_flags), .sw_we(sw_we), .sw_data(sw_data),
        .rti_we(rti_we), .rti_data(rti_data), .ent_xirq(ent_xirq), .ent_irq(ent_irq),
        .xirq_req(xirq_req), .irq_req(irq_req), .stop_req(stop_req),
        .ccr_q(ccr_q), .take_xirq(take_xirq), .take_irq(take_irq),
        .stop_go(stop_go), .stop_nop(stop_nop)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_word();
        return 8'(mS*128 + mX*64 + mH*32 + mI*16 + mN*8 + mZ*4 + mV*2 + mC);
    endfunction

    // advance the model by one clock edge using the inputs held this cycle
    task automatic model_edge();
        logic [7:0] d;
        if (!rst_n) begin
            mS = 1; mX = 1; mI = 1; mH = 0; mN = 0; mZ = 0; mV = 0; mC = 0; mPend = 0;
            m_valid = 1;
            return;
        end
        if (rti_we || sw_we) begin
            d = rti_we ? rti_data : sw_data;
            mS = d[7]; mH = d[5]; mI = d[4];
            mN = d[3]; mZ = d[2]; mV = d[1]; mC = d[0];
            if (d[6] == 1'b0) mX = 0;
        end else if (alu_upd) begin
            if (alu_kind == 2'd0) begin
                if (alu_we[3]) mN = alu_flags[3];
                if (alu_we[2]) mZ = alu_flags[2];
                if (alu_we[1]) mV = alu_flags[1];
                if (alu_we[0]) mC = alu_flags[0];
            end else if (alu_kind == 2'd1) begin
                mH = alu_flags[4]; mN = alu_flags[3]; mZ = alu_flags[2];
                mV = alu_flags[1]; mC = alu_flags[0];
            end else if (alu_kind == 2'd2) begin
                mZ = alu_flags[2];
            end
        end
        if (ent_xirq) begin mX = 1; mI = 1; end
        if (ent_irq) mI = 1;
        mPend = ((mPend != 0) && !ent_irq) || irq_req;
    endtask

    // one clock: compare every output with the model, then take the edge
    task automatic cyc(input string tag);
        int ex_tx, ex_ti;
        #1;
        if (m_valid) begin
            chk(tag, ccr_q, model_word());
            ex_tx = (xirq_req && mX == 0) ? 1 : 0;
            ex_ti = ((mPend != 0 || irq_req) && mI == 0 && ex_tx == 0) ? 1 : 0;
            chk("R7 take_xirq", {7'd0, take_xirq}, 8'(ex_tx));
            chk("R10/R11 take_irq", {7'd0, take_irq}, 8'(ex_ti));
            chk("R12 stop_go", {7'd0, stop_go}, 8'((stop_req && mS == 0) ? 1 : 0));
            chk("R12 stop_nop", {7'd0, stop_nop}, 8'((stop_req && mS == 1) ? 1 : 0));
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        alu_upd = 0; alu_kind = 2'd3; alu_we = '0; alu_flags = '0;
        sw_we = 0; rti_we = 0; ent_xirq = 0; ent_irq = 0;
        irq_req = 0; stop_req = 0; xirq_req = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; idle();
        cyc("R1"); cyc("R1");
        rst_n = 1;
        cyc("R1");
        chk("R1 reset value", ccr_q, 8'hD0);
    endtask

    task automatic sw_write(input logic [7:0] v, input string tag);
        sw_data = v; sw_we = 1; cyc(tag); idle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        cyc("R1");

        // R5: clear everything including X, then try to set all bits
        sw_write(8'h00, "R5"); cyc("R5");
        chk("R5 cleared", ccr_q, 8'h00);
        sw_write(8'hFF, "R5"); cyc("R5");
        chk("R5 X stays clear", ccr_q, 8'hBF);

        // R2: masked flag updates with several enable/value patterns
        sw_write(8'h00, "R2");
        for (int k = 0; k < 6; k++) begin
            alu_upd = 1; alu_kind = 2'd0;
            alu_we = 4'(k * 5 + 1); alu_flags = 5'(k * 7 + 19);
            cyc("R2");
        end
        idle(); cyc("R2");

        // R3: add class loads H with N,Z,V,C
        for (int k = 0; k < 4; k++) begin
            alu_upd = 1; alu_kind = 2'd1; alu_flags = 5'(k * 11 + 17);
            cyc("R3");
        end
        idle(); cyc("R3");

        // R4: index step touches Z only; class 3 touches nothing
        alu_upd = 1; alu_kind = 2'd1; alu_flags = 5'h1F; cyc("R4");
        alu_kind = 2'd2; alu_flags = 5'h00; cyc("R4");
        alu_kind = 2'd2; alu_flags = 5'h04; cyc("R4");
        alu_kind = 2'd3; alu_flags = 5'h00; cyc("R4");
        idle(); cyc("R4");
        chk("R4 only Z moved", ccr_q, 8'h2F);

        // R12: stop decision with S=0 then S=1
        sw_write(8'h00, "R12");
        stop_req = 1; cyc("R12"); idle();
        sw_write(8'h80, "R12");
        stop_req = 1; cyc("R12"); idle(); cyc("R12");

        // R10: request while I=1 is remembered, taken when I clears
        sw_write(8'h10, "R10");
        irq_req = 1; cyc("R10"); idle();
        cyc("R10"); cyc("R10");
        sw_write(8'h00, "R10");
        cyc("R10");
        chk("R10 take after I clear", {7'd0, take_irq}, 8'd1);
        // R9: maskable entry sets I, X unchanged, pending cleared
        ent_irq = 1; cyc("R9"); idle(); cyc("R9");
        chk("R9 I set X clear", ccr_q & 8'h50, 8'h10);
        chk("R10 pending cleared", {7'd0, take_irq}, 8'd0);

        // R11: both eligible, non-maskable wins
        sw_write(8'h00, "R11");
        irq_req = 1; xirq_req = 1; cyc("R11");
        irq_req = 0; cyc("R11");
        // R8: non-maskable entry sets X and I despite a load that cycle
        ent_xirq = 1; sw_data = 8'h0F; sw_we = 1; cyc("R8");
        idle(); cyc("R8");
        chk("R8 X and I set", ccr_q & 8'h50, 8'h50);
        cyc("R10");

        // R6: restore clears X, cannot set it, beats software and ALU
        rti_data = 8'h0A; rti_we = 1; cyc("R6"); idle(); cyc("R6");
        rti_data = 8'h55; rti_we = 1; sw_data = 8'hAA; sw_we = 1;
        alu_upd = 1; alu_kind = 2'd1; alu_flags = 5'h1F; cyc("R6");
        idle(); cyc("R6");
        chk("R6 restore wins, X clear-only", ccr_q, 8'h15);
        sw_data = 8'h33; sw_we = 1; alu_upd = 1; alu_kind = 2'd1; alu_flags = 5'h00;
        cyc("R6"); idle(); cyc("R6");

        // R7: non-maskable ignored while X=1 after reset
        do_reset();
        xirq_req = 1; cyc("R7"); cyc("R7");
        chk("R7 masked by X", {7'd0, take_xirq}, 8'd0);
        idle(); cyc("R7");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule